// File: doc/BRIEF.md
# Word-Programmed SPI Master with Register Interface

This block is an SPI master that software runs one frame at a time through a small register window. Software puts outgoing words into a four-entry transmit queue and writes a command word that holds the clock mode, the bit order, the byte order, the frame length minus one, the transmit and receive enables, the chip-select choice and a start bit. The shift engine then sends one frame of 1 to 32 bits on the serial lines. It raises a ready flag when the frame ends. If receive is enabled, it puts the captured word into a four-entry receive queue, aligned to bit 0.

The chip select can follow the frame, so the selected line is low only while a frame is in progress. Software can also hold it at a level it chooses. Queue faults are kept in sticky flags that software clears by writing ones. Writing a flush bit empties a queue, and the bit reads back as one until the flush has been done. The serial clock comes from the system clock through a fixed power-of-two divider. A second configuration register holds two trim fields that are stored and read back only.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the command register reads 0, the trim register reads the tap reset values (TX field in bits 14:10 = 9, RX field in bits 7:0 = 12), transfer status reads 0, FIFO status reads 0x5 (TX empty bit 2, RX empty bit 0), all chip selects are high and SCK is low.
- R2: The command register at 0x000 keeps bits 30, 29:28 (mode), 27:26 (select), 21 (software select), 20 (select level), 16 (LSB first), 15 (byte swap), 12 (RX enable), 11 (TX enable) and 4:0 (length minus one), and reads 0 in all other bits. Bit 31 reads 1 while a frame is in progress.
- R3: Writing the command register with bit 31 set while idle starts one frame of len+1 bits. SCK toggles exactly 2*(len+1) times, with 2^DIV_LOG2 system clocks between toggles. A bit-31 write during a frame starts nothing and takes no TX word.
- R4: Mode bit 29 is the SCK idle level, which also holds between frames. Mode bit 28 clear samples MISO on the leading edge; set, it samples on the trailing edge. Bits go out MSB first unless bit 16 is set.
- R5: With bit 15 set, the byte order of the 32-bit TX word is reversed before it is shifted, and the byte order of the received word is reversed before it is queued.
- R6: With RX enabled, the word captured in a frame is queued right-aligned. If the RX queue is full, the word is dropped and RX overflow (status bit 5) sets.
- R7: Writes to 0x108 enter the 4-word TX queue. A write to a full queue is dropped and sets TX overflow (bit 7). A start with TX enabled and an empty queue shifts zeros and sets TX underrun (bit 6). With TX disabled, zeros are shifted and nothing is taken from the queue.
- R8: A read of 0x188 takes the oldest RX word. A read with the queue empty returns 0 and sets RX underrun (bit 4).
- R9: Transfer status bit 30 (at 0x010) sets when a frame ends and clears when a 1 is written to it.
- R10: Writing 1 to FIFO status bit 15 (RX) or bit 14 (TX) makes the bit read 1 in the next cycle. The queue is then emptied and the bit clears.
- R11: Status bits 7:4 stay set until a 1 is written to them; writing 0 leaves them set. Bit 8 is their OR. Bits 3:0 show TX full, TX empty, RX full and RX empty as they stand.
- R12: With bit 21 set, the selected chip-select line follows bit 20 (0 = asserted low). With bit 21 clear, it is low only during a frame. The unselected lines stay high.
- R13: The trim register at 0x004 stores bits 14:10 and 7:0, reads 0 elsewhere, and has no effect on serial timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the RX port takes a word) |
| reg_addr | input | 10 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
A slave model in the bench records MOSI and drives MISO on the sampling edge that the mode selects, across all four modes, both bit orders, byte swap and frame lengths of 8, 12, 16 and 32 bits. An engine that sampled on the wrong edge or counted the length off by one would return a shifted or truncated word, or toggle SCK the wrong number of times. The queue corner cases are a write to a full TX queue, a start with the TX queue empty, a fifth received word with the RX queue full, and a read with the RX queue empty. Each has its own sticky flag, and a design that did not drop the word or raise the flag would show a wrong level or a wrong flag. A second start written in the middle of a frame must not take a TX word; a design that restarted would use up the second word. A flush must read back as pending for exactly one cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 10;
    localparam int unsigned CS_CNT = 4;

    localparam logic [ADDR_W-1:0] A_CMD   = 10'h000;
    localparam logic [ADDR_W-1:0] A_TRIM  = 10'h004;
    localparam logic [ADDR_W-1:0] A_XSTAT = 10'h010;
    localparam logic [ADDR_W-1:0] A_FSTAT = 10'h014;
    localparam logic [ADDR_W-1:0] A_TXP   = 10'h108;
    localparam logic [ADDR_W-1:0] A_RXP   = 10'h188;

    localparam logic [DATA_W-1:0] CMD_KEEP  = 32'h7C31_981F;
    localparam logic [DATA_W-1:0] TRIM_KEEP = 32'h0000_7CFF;

    localparam int unsigned XS_READY = 30;
    localparam int unsigned FS_RXFL  = 15;
    localparam int unsigned FS_TXFL  = 14;

    typedef struct packed {
        logic       go;
        logic       master;
        logic [1:0] mode;
        logic [1:0] cs_sel;
        logic [3:0] pad_a;
        logic       cs_sw;
        logic       cs_lvl;
        logic [2:0] pad_b;
        logic       lsb_first;
        logic       byte_swap;
        logic [1:0] pad_c;
        logic       rx_en;
        logic       tx_en;
        logic [5:0] pad_d;
        logic [4:0] len_m1;
    } cmd_t;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [4:0] len_m1;
        logic       lsb_first;
        logic       byte_swap;
        logic       rx_en;
    } frame_cfg_t;

    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic sel_bit(input logic [DATA_W-1:0] w,
                                     input logic [4:0] idx,
                                     input logic [4:0] len_m1,
                                     input logic lsb);
        logic [4:0] pos;
        pos = lsb ? idx : (len_m1 - idx);
        return w[pos];
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop)  rp_q <= step(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int DIV_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi
);
    localparam int HALF  = 1 << DIV_LOG2;
    localparam int DIV_W = (DIV_LOG2 > 0) ? DIV_LOG2 : 1;

    logic [DIV_W-1:0]  div_q;
    logic [6:0]        tog_q;
    logic [5:0]        tx_idx_q, rx_idx_q;
    logic              cpha_q, lsb_q, swap_q, rxen_q;
    logic [4:0]        len_q;
    logic [DATA_W-1:0] word_q, acc_q;
    logic [DATA_W-1:0] start_word;
    logic [6:0]        last_tog;
    logic              tick, leading, shift_ev, samp_ev;

    assign start_word = cfg.byte_swap ? swap_bytes(tx_word) : tx_word;
    assign tick       = (div_q == DIV_W'(HALF - 1));
    assign last_tog   = {1'b0, len_q, 1'b1};
    assign leading    = ~tog_q[0];
    assign shift_ev   = cpha_q ? leading : ~leading;
    assign samp_ev    = cpha_q ? ~leading : leading;
    assign rx_valid   = done && rxen_q;
    assign rx_word    = swap_q ? swap_bytes(acc_q) : acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            div_q    <= '0;
            tog_q    <= '0;
            tx_idx_q <= '0;
            rx_idx_q <= '0;
            cpha_q   <= 1'b0;
            lsb_q    <= 1'b0;
            swap_q   <= 1'b0;
            rxen_q   <= 1'b0;
            len_q    <= '0;
            word_q   <= '0;
            acc_q    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy     <= 1'b1;
                div_q    <= '0;
                tog_q    <= '0;
                rx_idx_q <= '0;
                acc_q    <= '0;
                sck      <= cfg.cpol;
                cpha_q   <= cfg.cpha;
                lsb_q    <= cfg.lsb_first;
                swap_q   <= cfg.byte_swap;
                rxen_q   <= cfg.rx_en;
                len_q    <= cfg.len_m1;
                word_q   <= start_word;
                if (!cfg.cpha) begin
                    mosi     <= sel_bit(start_word, 5'd0, cfg.len_m1, cfg.lsb_first);
                    tx_idx_q <= 6'd1;
                end else begin
                    mosi     <= 1'b0;
                    tx_idx_q <= 6'd0;
                end
            end else if (busy) begin
                if (tick) begin
                    div_q <= '0;
                    sck   <= ~sck;
                    tog_q <= tog_q + 7'd1;
                    if (shift_ev) begin
                        mosi     <= sel_bit(word_q, tx_idx_q[4:0], len_q, lsb_q);
                        tx_idx_q <= tx_idx_q + 6'd1;
                    end
                    if (samp_ev) begin
                        if (lsb_q) acc_q[rx_idx_q[4:0]] <= miso;
                        else       acc_q <= {acc_q[DATA_W-2:0], miso};
                        rx_idx_q <= rx_idx_q + 6'd1;
                    end
                    if (tog_q == last_tog) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int              FIFO_DEPTH = 4,
    parameter int              DIV_LOG2   = 1,
    parameter logic [4:0]      TAP_TX_RST = 5'd9,
    parameter logic [7:0]      TAP_RX_RST = 8'd12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [9:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [3:0]        spi_cs_n
);
    localparam logic [DATA_W-1:0] TRIM_RST = {17'd0, TAP_TX_RST, 2'd0, TAP_RX_RST};

    cmd_t              cmd_q, wcmd;
    logic [DATA_W-1:0] trim_q;
    logic              rdy_q, fl_rx_q, fl_tx_q;
    logic [3:0]        err_q, err_set, err_clr;

    logic wr_cmd, wr_trim, wr_xstat, wr_fstat, wr_txp, rd_rxp;
    logic go_req, start;

    logic              tx_full, tx_empty, tx_pop;
    logic [DATA_W-1:0] tx_dout, eng_tx;
    logic              rx_full, rx_empty;
    logic [DATA_W-1:0] rx_dout;

    frame_cfg_t        cfg;
    logic              eng_busy, eng_done, eng_rx_valid, eng_sck;
    logic [DATA_W-1:0] eng_rx_word;

    assign wcmd     = cmd_t'(reg_wdata);
    assign wr_cmd   = reg_wr && (reg_addr == A_CMD);
    assign wr_trim  = reg_wr && (reg_addr == A_TRIM);
    assign wr_xstat = reg_wr && (reg_addr == A_XSTAT);
    assign wr_fstat = reg_wr && (reg_addr == A_FSTAT);
    assign wr_txp   = reg_wr && (reg_addr == A_TXP);
    assign rd_rxp   = reg_rd && (reg_addr == A_RXP);

    assign go_req = wr_cmd && wcmd.go;
    assign start  = go_req && !eng_busy;
    assign tx_pop = start && wcmd.tx_en && !tx_empty;
    assign eng_tx = (wcmd.tx_en && !tx_empty) ? tx_dout : '0;

    assign cfg.cpol      = wcmd.mode[1];
    assign cfg.cpha      = wcmd.mode[0];
    assign cfg.len_m1    = wcmd.len_m1;
    assign cfg.lsb_first = wcmd.lsb_first;
    assign cfg.byte_swap = wcmd.byte_swap;
    assign cfg.rx_en     = wcmd.rx_en;

    // sticky sources: {tx overflow, tx underrun, rx overflow, rx underrun}
    assign err_set = {wr_txp && tx_full,
                      start && wcmd.tx_en && tx_empty,
                      eng_rx_valid && rx_full,
                      rd_rxp && rx_empty};
    assign err_clr = wr_fstat ? reg_wdata[7:4] : 4'b0000;

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(fl_tx_q),
        .push(wr_txp), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_dout),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(fl_rx_q),
        .push(eng_rx_valid), .din(eng_rx_word),
        .pop(rd_rxp), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty)
    );

    spim_shift #(.DIV_LOG2(DIV_LOG2)) u_eng (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg),
        .tx_word(eng_tx), .miso(spi_miso),
        .busy(eng_busy), .done(eng_done),
        .rx_valid(eng_rx_valid), .rx_word(eng_rx_word),
        .sck(eng_sck), .mosi(spi_mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            trim_q  <= TRIM_RST;
            rdy_q   <= 1'b0;
            fl_rx_q <= 1'b0;
            fl_tx_q <= 1'b0;
            err_q   <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= cmd_t'(reg_wdata & CMD_KEEP);
            if (wr_trim) trim_q <= reg_wdata & TRIM_KEEP;
            rdy_q   <= eng_done | (rdy_q & ~(wr_xstat & reg_wdata[XS_READY]));
            fl_rx_q <= wr_fstat && reg_wdata[FS_RXFL];
            fl_tx_q <= wr_fstat && reg_wdata[FS_TXFL];
            err_q   <= err_set | (err_q & ~err_clr);
        end
    end

    assign spi_sck = eng_busy ? eng_sck : cmd_q.mode[1];

    for (genvar g = 0; g < CS_CNT; g++) begin : g_cs
        always_comb begin
            if (cmd_q.cs_sel != 2'(g))  spi_cs_n[g] = 1'b1;
            else if (cmd_q.cs_sw)       spi_cs_n[g] = cmd_q.cs_lvl;
            else                        spi_cs_n[g] = ~eng_busy;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CMD:   reg_rdata = {eng_busy, 31'(cmd_q) };
            A_TRIM:  reg_rdata = trim_q;
            A_XSTAT: reg_rdata[XS_READY] = rdy_q;
            A_FSTAT: reg_rdata = {16'd0, fl_rx_q, fl_tx_q, 5'd0, |err_q, err_q,
                                  tx_full, tx_empty, rx_full, rx_empty};
            A_RXP:   reg_rdata = rx_empty ? '0 : rx_dout;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
    import spim_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        rdy,
    input logic        cs_sw,
    input logic [3:0]  cs_n,
    input logic        tx_pop,
    input logic        tx_ovf,
    input logic        reg_wr,
    input logic [9:0]  reg_addr,
    input logic [31:0] reg_wdata
);
    AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1); // R12

    AST_HW_CS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (busy && !cs_sw) |-> (cs_n != 4'hF)); // R12

    AST_READY_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |=> rdy); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3

    AST_NO_POP_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && (reg_addr == A_CMD) && reg_wdata[31]) |-> !tx_pop); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_ovf) |-> $past(reg_wr && (reg_addr == A_FSTAT) && reg_wdata[7])); // R11

endmodule

bind spim_ctrl spim_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .busy(eng_busy), .done(eng_done), .rdy(rdy_q),
    .cs_sw(cmd_q.cs_sw), .cs_n(spi_cs_n), .tx_pop(tx_pop), .tx_ovf(err_q[3]),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [3:0]  spi_cs_n;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    spim_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // behavioural reference state
    logic [31:0] m_txq[$];
    logic [31:0] m_rxq[$];
    logic        m_tovf = 0, m_tunr = 0, m_rovf = 0, m_runr = 0;

    // serial slave / monitor state
    logic        mon_cpol = 0, mon_cpha = 0, mon_lsb = 0, mon_cs_seen = 0;
    int          mon_n = 8, mon_tog = 0, mon_since = 0, mon_badint = 0, mon_sidx = 0;
    logic [31:0] mon_cap = 0, mon_slv = 0;
    logic [3:0]  mon_cs = 4'hF;
    logic        prev_sck = 0;

    always @(negedge clk) begin
        if (!rst) begin
            mon_since = mon_since + 1;
            if (spi_sck != prev_sck) begin
                mon_tog = mon_tog + 1;
                if (mon_tog > 1 && mon_since != HALF) mon_badint = mon_badint + 1;
                mon_since = 0;
                if (!mon_cs_seen) begin mon_cs = spi_cs_n; mon_cs_seen = 1; end
                if ((spi_sck != mon_cpol) != mon_cpha) begin
                    if (mon_lsb) mon_cap[mon_sidx] = spi_mosi;
                    else         mon_cap = {mon_cap[30:0], spi_mosi};
                    mon_sidx = mon_sidx + 1;
                    if (mon_sidx < mon_n) spi_miso = mon_slv[mon_n-1-mon_sidx];
                end
            end
            prev_sck = spi_sck;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] exp_fstat();
        logic [31:0] f = 0;
        f[8] = m_tovf | m_tunr | m_rovf | m_runr;
        f[7] = m_tovf; f[6] = m_tunr; f[5] = m_rovf; f[4] = m_runr;
        f[3] = (m_txq.size() == 4); f[2] = (m_txq.size() == 0);
        f[1] = (m_rxq.size() == 4); f[0] = (m_rxq.size() == 0);
        return f;
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] mode, input logic [1:0] sel,
                                       input logic sw, input logic lvl, input logic lsb,
                                       input logic swp, input logic rx, input logic tx,
                                       input logic [4:0] lm1);
        logic [31:0] c = 0;
        c[31] = 1; c[30] = 1; c[29:28] = mode; c[27:26] = sel; c[21] = sw; c[20] = lvl;
        c[16] = lsb; c[15] = swp; c[12] = rx; c[11] = tx; c[4:0] = lm1;
        return c;
    endfunction

    task automatic push_tx(input logic [31:0] w);
        if (m_txq.size() < 4) m_txq.push_back(w); else m_tovf = 1;
        wr(10'h108, w);
    endtask

    task automatic pop_rx(input string req);
        logic [31:0] d, e;
        if (m_rxq.size() > 0) e = m_rxq.pop_front(); else begin e = 0; m_runr = 1; end
        rd(10'h188, d);
        chk(req, d, e);
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            rd(10'h000, d);
            if (!d[31]) break;
        end
    endtask

    task automatic frame(input logic [31:0] c, input logic [31:0] slv,
                         input bit rego, input string req);
        logic [31:0] w, mask, s, rx, d;
        int n;
        n = int'(c[4:0]) + 1;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
        wr(10'h000, c & 32'h7FFF_FFFF);
        @(negedge clk);
        mon_cpol = c[29]; mon_cpha = c[28]; mon_lsb = c[16]; mon_n = n;
        mon_tog = 0; mon_since = 0; mon_badint = 0; mon_sidx = 0; mon_cap = 0;
        mon_slv = slv; mon_cs_seen = 0; spi_miso = slv[n-1];
        // reference expectations
        w = 0;
        if (c[11]) begin
            if (m_txq.size() > 0) w = m_txq.pop_front(); else m_tunr = 1;
        end
        if (c[15]) w = bswap(w);
        s = slv & mask;
        rx = s;
        if (c[16]) begin
            rx = 0;
            for (int i = 0; i < n; i++) rx[i] = s[n-1-i];
        end
        if (c[15]) rx = bswap(rx);
        if (c[12]) begin
            if (m_rxq.size() < 4) m_rxq.push_back(rx); else m_rovf = 1;
        end
        wr(10'h000, c);
        if (rego) begin
            repeat (10) @(negedge clk);
            rd(10'h000, d);
            chk("R2 busy bit during frame", {31'd0, d[31]}, 32'd1);
            wr(10'h000, c);
        end
        wait_idle();
        chk({req, " mosi word"}, mon_cap & mask, w & mask);
        chk("R3 sck toggle count", mon_tog, 2 * n);
        chk("R3 sck half period", mon_badint, 0);
        rd(10'h010, d);
        chk("R9 ready set", d, 32'h4000_0000);
        wr(10'h010, 32'h4000_0000);
        rd(10'h010, d);
        chk("R9 ready cleared", d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(10'h000, d); chk("R1 cmd reset", d, 0);
        rd(10'h004, d); chk("R1 trim reset", d, (32'd9 << 10) | 32'd12);
        rd(10'h010, d); chk("R1 xstat reset", d, 0);
        rd(10'h014, d); chk("R1 fstat reset", d, 32'h5);
        chk("R1 cs reset", {28'd0, spi_cs_n}, 32'hF);
        chk("R1 sck reset", {31'd0, spi_sck}, 0);

        // R2 readback mask, R4 idle level
        wr(10'h000, 32'h7FFF_FFFF);
        rd(10'h000, d); chk("R2 cmd readback", d, 32'h7C31_981F);
        chk("R4 sck idle follows cpol", {31'd0, spi_sck}, 1);
        wr(10'h000, 0);

        // R13 trim stored only
        wr(10'h004, 32'hFFFF_FFFF);
        rd(10'h004, d); chk("R13 trim readback", d, 32'h7CFF);

        // R3 R6 R12 mode 0, 8-bit, hardware select on line 2
        push_tx(32'hA5);
        frame(mk(2'd0, 2'd2, 0, 0, 0, 0, 1, 1, 5'd7), 32'h3C, 0, "R3");
        chk("R12 hw select in frame", {28'd0, mon_cs}, 32'hB);
        chk("R12 hw select after frame", {28'd0, spi_cs_n}, 32'hF);
        pop_rx("R6 rx word mode0");

        // R4 mode 3, lsb first, 32-bit
        push_tx(32'h1234_5678);
        frame(mk(2'd3, 2'd0, 0, 0, 1, 0, 1, 1, 5'd31), 32'h80F0_0F01, 0, "R4 mode3 lsb");
        pop_rx("R4 rx mode3 lsb");
        chk("R4 sck idle high after mode3", {31'd0, spi_sck}, 1);

        // R5 byte swap, mode 1
        push_tx(32'h1122_3344);
        frame(mk(2'd1, 2'd1, 0, 0, 0, 1, 1, 1, 5'd31), 32'hCAFE_0042, 0, "R5 swap");
        pop_rx("R5 rx swapped");

        // R4 mode 2, 12-bit
        push_tx(32'h0000_0ABC);
        frame(mk(2'd2, 2'd3, 0, 0, 0, 0, 1, 1, 5'd11), 32'h5A3, 0, "R4 mode2");
        pop_rx("R4 rx mode2");

        // R12 software select
        wr(10'h000, 32'h0420_0000);
        chk("R12 sw select low", {28'd0, spi_cs_n}, 32'hD);
        wr(10'h000, 32'h0430_0000);
        chk("R12 sw select high", {28'd0, spi_cs_n}, 32'hF);

        // R7 R10 R11 tx overflow, sticky flags, flush
        for (int i = 1; i <= 5; i++) push_tx(i);
        rd(10'h014, d); chk("R7 tx overflow", d, exp_fstat());
        wr(10'h014, 0);
        rd(10'h014, d); chk("R11 zero write keeps flags", d, exp_fstat());
        wr(10'h014, 32'h4000);
        rd(10'h014, d); chk("R10 tx flush pending", d, exp_fstat() | 32'h4000);
        m_txq.delete();
        rd(10'h014, d); chk("R10 tx flush done", d, exp_fstat());
        wr(10'h014, 32'h80); m_tovf = 0;
        rd(10'h014, d); chk("R11 w1c clears", d, exp_fstat());

        // R7 underrun
        frame(mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 1, 5'd7), 32'hFF, 0, "R7 underrun");
        rd(10'h014, d); chk("R7 underrun flag", d, exp_fstat());
        wr(10'h014, 32'h40); m_tunr = 0;

        // R6 R8 rx overflow and underrun, tx disabled shifts zeros
        for (int k = 1; k <= 5; k++)
            frame(mk(2'd0, 2'd0, 0, 0, 0, 0, 1, 0, 5'd15), 32'h1111 * k, 0, "R7 tx disabled");
        rd(10'h014, d); chk("R6 rx overflow", d, exp_fstat());
        for (int k = 0; k < 5; k++) pop_rx("R8 rx read");
        rd(10'h014, d); chk("R8 rx underrun", d, exp_fstat());
        wr(10'h014, 32'h30); m_rovf = 0; m_runr = 0;

        // R3 second start during a frame is ignored
        push_tx(32'hDEAD_BEEF);
        push_tx(32'h0BAD_F00D);
        frame(mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 1, 5'd31), 0, 1, "R3 rego");
        rd(10'h014, d); chk("R3 one word taken", d, exp_fstat());
        wr(10'h014, 32'h4000); @(negedge clk); m_txq.delete();

        // R10 rx flush
        frame(mk(2'd0, 2'd0, 0, 0, 0, 0, 1, 0, 5'd7), 32'h77, 0, "R10 pre");
        wr(10'h014, 32'h8000);
        rd(10'h014, d); chk("R10 rx flush pending", d, exp_fstat() | 32'h8000);
        m_rxq.delete();
        rd(10'h014, d); chk("R10 rx flush done", d, exp_fstat());

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule